// File: doc/BRIEF.md
# Host Interrupt Request Handshake

This block turns a request from an embedded controller into a host interrupt and holds it there. The controller asks for service by pulling an asynchronous pin low for a short time. The block brings the pin into the host clock domain and accepts the request only if the low level lasts long enough. It then raises a sticky pending flag that stays set until the host writes an explicit acknowledge. The interrupt line is level-type and shareable: the block only ever asks for the line to be pulled low and otherwise releases it.

The host sees two 32-bit registers through a small write port and a combinational read port. One holds the enable and pending bits. The other is a write-only acknowledge strobe. While a request is pending, further requests from the controller are dropped rather than queued. The controller must issue a fresh pulse after the host has acknowledged.

Top module: `host_irq_handshake`

## Requirements
- R1: After reset the pending flag and the enable bit are 0, both registers read 0 and `irq_pull` is 0.
- R2: The pin passes through a two-flop synchronizer, and a low level seen on MIN_LOW_CYC (default 10) consecutive rising edges counts as a request. If the pin is first seen low at edge 1 and held low through edge MIN_LOW_CYC, pending reads 1 from edge MIN_LOW_CYC+2 and still reads 0 between edges MIN_LOW_CYC+1 and MIN_LOW_CYC+2.
- R3: A low level seen on fewer than MIN_LOW_CYC consecutive edges is ignored, and pending stays 0.
- R4: One low period gives at most one request. If the pin is still held low after an acknowledge, no new request is raised until the pin has returned high and fallen again.
- R5: The status register (`host_sel`=0) reads bit 6 = enable and bit 2 = pending, with every other bit 0. A write to it updates only the enable bit from bit 6, and bit 2 of the written data is ignored.
- R6: A write to the acknowledge register (`host_sel`=1) with bit 8 set clears pending at that clock edge. With bit 8 clear the write has no effect. This register always reads 0.
- R7: A qualified request that arrives while pending is already 1 is discarded. After the acknowledge, pending is 0 and stays 0.
- R8: `irq_pull` is 1 exactly when pending and enable are both 1. A request is captured into pending even while the enable bit is 0, and it drives the line once the enable bit is set.
- R9: When an acknowledge write and a newly qualified request fall on the same clock edge, the new request wins and pending is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_req_n | input | 1 | Asynchronous request pin from the controller, active low |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 status/enable, 1 acknowledge |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register, combinational |
| irq_pull | output | 1 | 1 = pull the shared interrupt line low; 0 = release it |

## Verification
The assertions check on every cycle the local cause-and-effect rules. Pending rises only after a qualified request and falls only after an acknowledge. It holds while no acknowledge arrives, and a same-edge acknowledge cannot clear it. Each qualification event lasts a single cycle, and the line is never pulled without both pending and enable. What only the bench scenarios can show is the end-to-end timing from pin to status bit, and the rejection of pulses one cycle too short. They also show that a request arriving during lockout is dropped for good, and that a pin held low across an acknowledge does not raise a second request.

// File: rtl/irqhs_pkg.sv
package irqhs_pkg;
  localparam int HOST_DW  = 32;
  localparam int ENA_POS  = 6;
  localparam int PEND_POS = 2;
  localparam int ACK_POS  = 8;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ACK    = 1'b1
  } host_sel_e;

  // Status word as the host reads it.
  function automatic logic [HOST_DW-1:0] status_word(input logic en, input logic pend);
    logic [HOST_DW-1:0] w;
    w           = '0;
    w[ENA_POS]  = en;
    w[PEND_POS] = pend;
    return w;
  endfunction

  // Next pending state: a fresh request outranks a same-edge acknowledge.
  function automatic logic next_pending(input logic cur, input logic hit, input logic ack);
    return hit | (cur & ~ack);
  endfunction
endpackage

// File: rtl/irqhs_sync.sv
module irqhs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  generate
    if (STAGES <= 1) begin : g_single
      logic ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= RST_VAL;
        else        ff <= d_async;
      end
      assign q_sync = ff;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
      end
      assign q_sync = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irqhs_pulse_qual.sv
module irqhs_pulse_qual #(
  parameter int MIN_LOW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic hit
);
  localparam int            CW    = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CMAX  = CW'(MIN_LOW);
  localparam logic [CW-1:0] CLAST = CW'(MIN_LOW - 1);

  // Count consecutive low samples, saturating so one low period fires once.
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run <= '0;
    else if (lvl)         run <= '0;
    else if (run != CMAX) run <= run + CW'(1);
  end

  assign hit = !lvl && (run == CLAST);
endmodule

// File: rtl/irqhs_regs.sv
module irqhs_regs
  import irqhs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic               wr,
  input  logic               sel,
  input  logic [HOST_DW-1:0] wdata,
  output logic [HOST_DW-1:0] rdata,
  output logic               pend,
  output logic               en,
  output logic               ack_stb
);
  logic cfg_wr;

  assign ack_stb = wr && (sel == SEL_ACK) && wdata[ACK_POS];
  assign cfg_wr  = wr && (sel == SEL_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      en   <= 1'b0;
    end else begin
      pend <= next_pending(pend, hit, ack_stb);
      if (cfg_wr) en <= wdata[ENA_POS];
    end
  end

  assign rdata = (sel == SEL_ACK) ? '0 : status_word(en, pend);
endmodule

// File: rtl/host_irq_handshake.sv
module host_irq_handshake
  import irqhs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_req_n,
  input  logic               host_wr,
  input  logic               host_sel,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               irq_pull
);
  // Named internal events, visible to the bound checker.
  logic sync_lvl;
  logic q_hit;
  logic pend_flag;
  logic en_bit;
  logic ack_stb;

  irqhs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ctrl_req_n),
    .q_sync  (sync_lvl)
  );

  irqhs_pulse_qual #(.MIN_LOW(MIN_LOW_CYC)) qual_i (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sync_lvl),
    .hit   (q_hit)
  );

  irqhs_regs regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (q_hit),
    .wr      (host_wr),
    .sel     (host_sel),
    .wdata   (host_wdata),
    .rdata   (host_rdata),
    .pend    (pend_flag),
    .en      (en_bit),
    .ack_stb (ack_stb)
  );

  // Drive-low request for a shared open-drain style line.
  assign irq_pull = pend_flag & en_bit;
endmodule

// File: rtl/irqhs_chk.sv
module irqhs_chk (
  input logic clk,
  input logic rst_n,
  input logic hit,
  input logic ack,
  input logic pend,
  input logic en,
  input logic irq
);
  // R2
  pend_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(hit));

  // R4
  hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  // R6
  pend_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(ack));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !pend);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend && en));

  // R9
  ack_vs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit) |=> pend);
endmodule

bind host_irq_handshake irqhs_chk chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .hit   (q_hit),
  .ack   (ack_stb),
  .pend  (pend_flag),
  .en    (en_bit),
  .irq   (irq_pull)
);

// File: tb/host_irq_handshake_tb_top.sv
`timescale 1ns/1ps
module host_irq_handshake_tb_top;
  localparam int MINW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_req_n = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq_pull;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  host_irq_handshake #(.SYNC_STAGES(2), .MIN_LOW_CYC(MINW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_req_n (ctrl_req_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq_pull   (irq_pull)
  );

  // Behavioural reference: history of raw pin samples plus two state bits.
  bit hist[$];
  bit m_pend = 1'b0;
  bit m_en = 1'b0;

  function automatic bit hist_at(int i);
    if (i < 0) return 1'b1;
    return hist[i];
  endfunction

  // Request accepted at this edge if the pin was low on the MINW samples
  // ending two edges ago and high just before them.
  function automatic bit req_now();
    int s = hist.size();
    if (hist_at(s - 2 - MINW) == 1'b0) return 1'b0;
    for (int k = 2; k <= MINW + 1; k++)
      if (hist_at(s - k)) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    bit ev;
    bit ack;
    if (!rst_n) begin
      hist.delete();
      m_pend = 1'b0;
      m_en   = 1'b0;
    end else begin
      ev  = req_now();
      ack = host_wr && host_sel && host_wdata[8];
      if (host_wr && !host_sel) m_en = host_wdata[6];
      m_pend = ev || (m_pend && !ack);
      hist.push_back(ctrl_req_n);
      if (hist.size() > MINW + 4) void'(hist.pop_front());
    end
  end

  // Compare against the reference on every clock, away from the edge.
  always @(negedge clk) begin
    logic [31:0] exp_rd;
    if (rst_n && !done) begin
      exp_rd = host_sel ? 32'h0 : ((32'(m_en) << 6) | (32'(m_pend) << 2));
      n_cmp++;
      if (irq_pull !== (m_pend && m_en)) begin
        n_bad++;
        $display("FAIL R8 per-cycle irq_pull: actual %b expected %b at %0t",
                 irq_pull, m_pend && m_en, $time);
      end
      n_cmp++;
      if (host_rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL R5 per-cycle rdata: actual %h expected %h at %0t",
                 host_rdata, exp_rd, $time);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(int k);
    ctrl_req_n = 1'b0;
    step(k);
    ctrl_req_n = 1'b1;
    step(1);
  endtask

  task automatic wr_reg(logic sel, logic [31:0] d);
    host_wr    = 1'b1;
    host_sel   = sel;
    host_wdata = d;
    step(1);
    host_wr    = 1'b0;
  endtask

  task automatic check_rd(logic sel, logic [31:0] exp, string tag);
    host_sel = sel;
    #1;
    n_cmp++;
    if (host_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: sel %0d actual %h expected %h", tag, sel, host_rdata, exp);
    end
    host_sel = 1'b0;
  endtask

  task automatic check_irq(logic exp, string tag);
    n_cmp++;
    if (irq_pull !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_pull actual %b expected %b", tag, irq_pull, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    step(2);

    // R1 reset state
    check_rd(1'b0, 32'h0, "R1 status after reset");
    check_rd(1'b1, 32'h0, "R1 ack reg after reset");
    check_irq(1'b0, "R1 line released");

    // R3 one cycle too short
    pulse(MINW - 1);
    step(15);
    check_rd(1'b0, 32'h0, "R3 short pulse ignored");

    // R5 only enable is writable, bit 2 and others ignored
    wr_reg(1'b0, 32'hFFFF_FFFF);
    check_rd(1'b0, 32'h40, "R5 enable only");
    check_irq(1'b0, "R5 no line without pending");

    // R2 exact latency
    pulse(MINW);
    check_rd(1'b0, 32'h40, "R2 not yet pending");
    step(1);
    check_rd(1'b0, 32'h44, "R2 pending set");
    check_irq(1'b1, "R8 line pulled");

    // R8 enable gates the line, not the flag
    wr_reg(1'b0, 32'h0000_0004);
    check_rd(1'b0, 32'h04, "R8 pending kept when disabled");
    check_irq(1'b0, "R8 line released when disabled");
    wr_reg(1'b0, 32'h40);
    check_irq(1'b1, "R8 line again when enabled");

    // R6 ack write without bit 8 does nothing; ack reg reads 0
    wr_reg(1'b1, 32'hFFFF_FEFF);
    check_rd(1'b0, 32'h44, "R6 no ack without bit 8");
    check_rd(1'b1, 32'h0, "R6 ack reg reads zero");

    // R7 lockout: request during pending is dropped
    pulse(MINW + 2);
    step(15);
    wr_reg(1'b1, 32'h100);
    check_rd(1'b0, 32'h40, "R7 cleared by ack");
    check_irq(1'b0, "R7 line released after ack");
    step(20);
    check_rd(1'b0, 32'h40, "R7 dropped request not replayed");

    // R4 pin held low across an ack
    ctrl_req_n = 1'b0;
    step(20);
    check_rd(1'b0, 32'h44, "R4 held low gives request");
    wr_reg(1'b1, 32'h100);
    check_rd(1'b0, 32'h40, "R4 ack clears");
    step(15);
    check_rd(1'b0, 32'h40, "R4 no second request while low");
    ctrl_req_n = 1'b1;
    step(3);
    check_rd(1'b0, 32'h40, "R4 release adds nothing");

    // R8 capture while disabled
    wr_reg(1'b0, 32'h0);
    pulse(MINW);
    step(3);
    check_rd(1'b0, 32'h04, "R8 captured while disabled");
    check_irq(1'b0, "R8 quiet while disabled");
    wr_reg(1'b0, 32'h40);
    check_irq(1'b1, "R8 line once enabled");

    // R9 ack on the very edge a new request qualifies
    ctrl_req_n = 1'b0;
    step(MINW);
    ctrl_req_n = 1'b1;
    step(1);
    wr_reg(1'b1, 32'h100);
    check_rd(1'b0, 32'h44, "R9 new request wins over ack");
    wr_reg(1'b1, 32'h100);
    check_rd(1'b0, 32'h40, "R9 later ack clears");
    check_rd(1'b1, 32'h0, "R6 ack reg still zero");

    step(2);
    finish_run();
  end
endmodule